// File: doc/BRIEF.md
# Serial Configuration Port with Address-Selected Latches

This block receives configuration words for a frequency synthesizer over three wires: a serial clock, a serial data line and a load-enable line. All three are sampled from a free-running system clock. Each one passes through a two-flop synchronizer, and the block acts on the edges it finds after the synchronizer. Each rising edge of the serial clock shifts one data bit into a 21-bit shift register, most significant bit first.

The last bit of a word is an address, not data. When load-enable rises, the upper 20 bits of the shift register are copied into one of two parallel latches. Address 1 selects the reference-divider latch and address 0 selects the main-divider latch. The block pulses a one-cycle update strobe with each load and shows which latch it wrote. The protocol requires the serial clock to be low whenever load-enable changes. If load-enable changes while the serial clock is high, a sticky error flag is set and the load still happens.

Top module: `serial_cfg_port`

## Requirements
- R1: Each rising edge of the synchronized serial clock shifts the synchronized data bit into the least significant end of a 21-bit shift register. The first bit sent therefore ends up as bit 20 of a word, and only the last 21 bits sent before a load count.
- R2: On a rising edge of synchronized load-enable, if shift register bit 0 is 1, then `ref_word` takes shift register bits 20..1. If bit 0 is 0, then `main_word` takes those bits.
- R3: A load leaves the latch it does not select unchanged.
- R4: Each load raises `upd_stb` for exactly one system clock cycle, in the same cycle the latch changes. At the same time `upd_sel_ref` takes the address bit (1 = reference latch, 0 = main latch) and holds it until the next load.
- R5: A falling edge of load-enable causes no load. Serial clock pulses that are not followed by a rising edge of load-enable also cause no load: neither latch changes and no strobe is produced.
- R6: An edge of load-enable in either direction, seen while the synchronized serial clock is high, sets `proto_err`. The flag stays set until reset, and the load that edge requests still takes place.
- R7: Reset clears both latches, `upd_stb`, `upd_sel_ref` and `proto_err`. During reset the block treats load-enable as sitting at its idle high level, so if load-enable is high when reset is released, no load occurs.
- R8: A latch update becomes visible at the outputs no more than three system-clock rising edges after load-enable rises at the input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial clock, asynchronous |
| ser_data | input | 1 | Serial data, MSB first |
| ser_le | input | 1 | Load enable, idle high |
| ref_word | output | 20 | Reference-divider latch |
| main_word | output | 20 | Main-divider latch |
| upd_stb | output | 1 | One-cycle pulse on each load |
| upd_sel_ref | output | 1 | Latch written by the last load (1 = reference) |
| proto_err | output | 1 | Sticky flag: load-enable changed while serial clock was high |

## Verification
If the shift register holds a wrong value, the next load puts a wrong word into a latch, or picks the wrong latch when bit 0 is affected. Either shows on `ref_word`/`main_word` and `upd_sel_ref` within three system clocks of load-enable rising. A broken edge detector shows as a missing or extra `upd_stb` pulse, or a load on the falling edge, in the same window. The error flag is checked both for setting on a clock-high edge and for staying set through later clean loads until reset.

// File: rtl/serial_cfg_port.sv
module serial_cfg_port #(
  parameter int PAYLOAD_W   = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ser_clk,
  input  logic                 ser_data,
  input  logic                 ser_le,
  output logic [PAYLOAD_W-1:0] ref_word,
  output logic [PAYLOAD_W-1:0] main_word,
  output logic                 upd_stb,
  output logic                 upd_sel_ref,
  output logic                 proto_err
);
  localparam int WORD_W = PAYLOAD_W + 1;
  localparam int S      = SYNC_STAGES;

  logic [S:0]        sck_q, dat_q, le_q;
  logic [WORD_W-1:0] shreg;

  wire sck_rise = sck_q[S-1] & ~sck_q[S];
  wire le_rise  = le_q[S-1] & ~le_q[S];
  wire le_edge  = le_q[S-1] ^ le_q[S];
  wire sck_high = sck_q[S-1];
  wire dat_now  = dat_q[S-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= '0;
      dat_q <= '0;
      le_q  <= '1;
    end else begin
      sck_q <= {sck_q[S-1:0], ser_clk};
      dat_q <= {dat_q[S-1:0], ser_data};
      le_q  <= {le_q[S-1:0], ser_le};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      shreg <= '0;
    else if (sck_rise)
      shreg <= {shreg[WORD_W-2:0], dat_now};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_word    <= '0;
      main_word   <= '0;
      upd_stb     <= 1'b0;
      upd_sel_ref <= 1'b0;
      proto_err   <= 1'b0;
    end else begin
      upd_stb <= le_rise;
      if (le_rise) begin
        upd_sel_ref <= shreg[0];
        if (shreg[0]) ref_word  <= shreg[WORD_W-1:1];
        else          main_word <= shreg[WORD_W-1:1];
      end
      if (le_edge && sck_high)
        proto_err <= 1'b1;
    end
  end
endmodule

module serial_cfg_port_chk #(
  parameter int PAYLOAD_W = 20
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [PAYLOAD_W-1:0] ref_word,
  input logic [PAYLOAD_W-1:0] main_word,
  input logic                 upd_stb,
  input logic                 upd_sel_ref,
  input logic                 proto_err
);
  p_stb_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    upd_stb |=> !upd_stb);
  p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> proto_err);
  p_ref_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_stb |-> $stable(ref_word));
  p_main_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_stb |-> $stable(main_word));
  p_sel_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_stb |-> $stable(upd_sel_ref));
  p_ref_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_stb && !upd_sel_ref) |-> $stable(ref_word));
  p_main_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_stb && upd_sel_ref) |-> $stable(main_word));
endmodule

bind serial_cfg_port serial_cfg_port_chk #(.PAYLOAD_W(PAYLOAD_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .ref_word(ref_word), .main_word(main_word),
  .upd_stb(upd_stb), .upd_sel_ref(upd_sel_ref), .proto_err(proto_err)
);

// File: tb/test_serial_cfg_port.sv
module test_serial_cfg_port;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_data = 1'b0, ser_le = 1'b1;
  logic [19:0] ref_word, main_word;
  logic upd_stb, upd_sel_ref, proto_err;

  int checks = 0, fails = 0, stb_cnt = 0;
  logic [19:0] ref_m = '0, main_m = '0;

  localparam logic [20:0] VEC [6] = '{
    21'h1FFFFF, 21'h1FFFFE, 21'h000001, 21'h0A5A5A, 21'h155555, 21'h1ABCD4
  };

  always #4 clk = ~clk;

  serial_cfg_port i_serial_cfg_port (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
    .ser_le(ser_le), .ref_word(ref_word), .main_word(main_word),
    .upd_stb(upd_stb), .upd_sel_ref(upd_sel_ref), .proto_err(proto_err)
  );

  always @(negedge clk) if (rst_n && upd_stb) stb_cnt++;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put_bit(input logic b);
    ser_data = b; wt(4);
    ser_clk = 1'b1; wt(4);
    ser_clk = 1'b0; wt(4);
  endtask

  task automatic shift_bits(input logic [31:0] w, input int n);
    for (int i = n - 1; i >= 0; i--) put_bit(w[i]);
  endtask

  task automatic load_word(input logic [31:0] w, input int n);
    ser_le = 1'b0; wt(4);
    shift_bits(w, n);
    ser_le = 1'b1; wt(8);
    if (w[0]) ref_m = w[20:1]; else main_m = w[20:1];
  endtask

  task automatic chk_latches(input string tag);
    chk(ref_word == ref_m, tag, ref_word, ref_m);
    chk(main_word == main_m, tag, main_word, main_m);
  endtask

  initial begin
    #1_000_000;
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int s0;
    wt(3);
    rst_n = 1'b1;
    wt(6);
    // R7 reset state
    chk(ref_word == 0 && main_word == 0, "R7 latches zero", {ref_word[15:0], main_word[15:0]}, 0);
    chk(!upd_stb && !upd_sel_ref && !proto_err, "R7 flags zero", {upd_stb, upd_sel_ref, proto_err}, 0);
    chk(stb_cnt == 0, "R7 no load with LE high", stb_cnt, 0);

    // R1 R2 R3 R4 vector walk
    foreach (VEC[k]) begin
      s0 = stb_cnt;
      load_word({11'd0, VEC[k]}, 21);
      chk_latches("R2 R3 vector");
      chk(upd_sel_ref == VEC[k][0], "R4 select", upd_sel_ref, VEC[k][0]);
      chk(stb_cnt == s0 + 1, "R4 one strobe", stb_cnt, s0 + 1);
    end
    chk(!proto_err, "R6 clean traffic no error", proto_err, 0);

    // R1 extra leading bits are dropped
    load_word({7'd0, 4'hF, 21'h02468A}, 25);
    chk_latches("R1 last 21 bits");

    // R8 latency: update visible within three edges of LE rising
    ser_le = 1'b0; wt(4);
    shift_bits({11'd0, 21'h0C3C3D}, 21);
    @(posedge clk); #1 ser_le = 1'b1;
    @(posedge clk); @(posedge clk); @(posedge clk); #1;
    ref_m = 20'h61E1E;
    chk(ref_word == ref_m, "R8 latency", ref_word, ref_m);
    wt(6);

    // R5 falling edge and bare shifting do not load
    s0 = stb_cnt;
    ser_le = 1'b0; wt(8);
    chk(stb_cnt == s0, "R5 fall no strobe", stb_cnt, s0);
    shift_bits({11'd0, 21'h1F0F0F}, 21);
    chk_latches("R5 shift no load");
    chk(stb_cnt == s0, "R5 shift no strobe", stb_cnt, s0);
    ser_le = 1'b1; wt(8);
    ref_m = 20'hF8787;
    chk_latches("R5 later rise loads");

    // R6 LE rises while serial clock high: error set, load happens
    ser_le = 1'b0; wt(4);
    shift_bits({12'd0, 20'h12345}, 20);
    ser_data = 1'b0; wt(4);
    ser_clk = 1'b1; wt(4);
    ser_le = 1'b1; wt(4);
    ser_clk = 1'b0; wt(8);
    main_m = 20'h12345;
    chk(proto_err == 1'b1, "R6 error set", proto_err, 1);
    chk_latches("R6 load still happens");
    load_word({11'd0, 21'h000003}, 21);
    chk(proto_err == 1'b1, "R6 error sticky", proto_err, 1);
    chk_latches("R6 later load");

    // R7 reset mid-run with LE high
    s0 = stb_cnt;
    rst_n = 1'b0; wt(3);
    rst_n = 1'b1; wt(10);
    chk(ref_word == 0 && main_word == 0, "R7 reset clears latches", {ref_word[15:0], main_word[15:0]}, 0);
    chk(!proto_err && !upd_sel_ref, "R7 reset clears flags", {upd_sel_ref, proto_err}, 0);
    chk(stb_cnt == s0, "R7 no load after reset", stb_cnt, s0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule